// File: doc/BRIEF.md
# Two-Bank CPU Register File with Stack-Pointer View

This block stores the general working registers of a small processor core. Every bank holds four 16-bit data registers, two 16-bit address registers and a frame base register. There are two banks. A bank-select input picks the live bank, and all accesses go to that bank only. Two 16-bit stack pointers, one for user code and one for interrupt handlers, exist only once. The core sees them through a single stack-pointer selector, and a stack-select input decides which physical pointer that selector reaches.

The block has one write port and one read port. Each port names a register with a 3-bit selector and an access size with a 2-bit code. A byte access reaches either half of data register 0 or data register 1. A word access reaches any single register. A pair access moves 32 bits through one of three fixed pairings. A selector and size that do not form a legal pairing raise an error flag. On the write port that error also cancels the write.

The read port is combinational from the stored state. A write takes effect at the rising clock edge. Reset is synchronous and active high.

Top module: `bankreg_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register in both banks and both stack pointers become zero. Every legal read after that returns zero.
- R2: Selector codes are 0 = data reg 0, 1 = data reg 1, 2 = data reg 2, 3 = data reg 3, 4 = address reg 0, 5 = address reg 1, 6 = frame base, 7 = stack-pointer view. With size code 2'b01 (word), a write stores `wr_data[15:0]` into the selected register. A word read returns that register on `rd_data[15:0]`. For every size other than pair (2'b10), `rd_data[31:16]` is zero.
- R3: Size code 2'b00 (byte) is legal only with selectors 0 and 1. The half-select bit set to 1 picks bits 15:8, and set to 0 picks bits 7:0. A byte write loads `wr_data[7:0]` into that half and leaves the other half unchanged. A byte read puts the half on `rd_data[7:0]` with zeros above it.
- R4: Size code 2'b10 (pair) is legal only with selectors 0, 1 and 4. These give data reg 2 : data reg 0, data reg 3 : data reg 1, and address reg 1 : address reg 0, high word first. A pair write updates both words at the same edge from `wr_data[31:16]` and `wr_data[15:0]`. A pair read returns the high word on `rd_data[31:16]`.
- R5: Size code 2'b11 is always illegal, and so is a byte or pair size with any selector not listed in R3 or R4. For an illegal write port, `wr_err` is high while `wr_en` is high, and the write changes no state. For an illegal read port, `rd_err` is high and `rd_data` is zero.
- R6: With `bank_sel` at 0 only bank 0 is read or written, and with 1 only bank 1. The other bank keeps its contents.
- R7: Selector 7 reaches the user stack pointer when `stack_sel` is 0 and the interrupt stack pointer when it is 1. It is legal only at word size. The pointer that is not selected is unchanged. Both pointers are shared by the two banks.
- R8: A read in the same cycle as a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Active bank (0 or 1) |
| stack_sel | input | 1 | Stack view target: 0 user, 1 interrupt |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Write register selector |
| wr_size | input | 2 | Write access size code |
| wr_hi | input | 1 | Write byte half: 1 upper, 0 lower |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Illegal write request (write dropped) |
| rd_sel | input | 3 | Read register selector |
| rd_size | input | 2 | Read access size code |
| rd_hi | input | 1 | Read byte half: 1 upper, 0 lower |
| rd_data | output | 32 | Read data, zero-extended below pair size |
| rd_err | output | 1 | Illegal read request (data forced to zero) |

## Verification
The bench builds the block with its default 16-bit word width. This gives 8-bit halves and a 32-bit pair bus, so every byte, word and pair pairing can be driven with literal values. Each vector reads before its own write commits. This exposes the old-value rule, shows that a byte write leaves the other half alone, and shows that dropped illegal writes leave no trace. Bank and stack-select sweeps confirm that the banked registers are separate per bank and that the two stack pointers are shared.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

    // Register selector codes shared by both ports
    typedef enum logic [2:0] {
        SEL_D0  = 3'd0,
        SEL_D1  = 3'd1,
        SEL_D2  = 3'd2,
        SEL_D3  = 3'd3,
        SEL_AD0 = 3'd4,
        SEL_AD1 = 3'd5,
        SEL_FRM = 3'd6,
        SEL_STK = 3'd7
    } regsel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_PAIR = 2'b10,
        SZ_RSVD = 2'b11
    } accsize_e;

    // Number of banked storage slots (selectors 0..6)
    localparam int unsigned NUM_SLOTS = 7;

    // Decoded access descriptor
    typedef struct packed {
        logic       ok;       // legal selector/size pairing
        logic       byte_op;
        logic       pair_op;
        logic       upper;    // byte half select
        logic       stack;    // targets the stack-pointer view
        logic [2:0] lo;       // slot of single word or low word
        logic [2:0] hi;       // slot of high word for pairs
    } access_t;

    function automatic logic [2:0] pair_partner(input regsel_e s);
        case (s)
            SEL_D0:  return SEL_D2;
            SEL_D1:  return SEL_D3;
            SEL_AD0: return SEL_AD1;
            default: return s;
        endcase
    endfunction

    function automatic logic byte_capable(input regsel_e s);
        return (s == SEL_D0) || (s == SEL_D1);
    endfunction

    function automatic logic pair_capable(input regsel_e s);
        return (s == SEL_D0) || (s == SEL_D1) || (s == SEL_AD0);
    endfunction

endpackage

// File: rtl/bankreg_decode.sv
`timescale 1ns/1ps
module bankreg_decode
    import bankreg_pkg::*;
(
    input  logic [2:0] sel,
    input  logic [1:0] size,
    input  logic       half,
    output access_t    acc
);
    regsel_e  s;
    accsize_e z;

    assign s = regsel_e'(sel);
    assign z = accsize_e'(size);

    always_comb begin
        acc         = '0;
        acc.lo      = sel;
        acc.hi      = pair_partner(s);
        acc.upper   = half;
        acc.stack   = (s == SEL_STK);
        case (z)
            SZ_BYTE: begin
                acc.byte_op = 1'b1;
                acc.ok      = byte_capable(s);
            end
            SZ_WORD: acc.ok = 1'b1;
            SZ_PAIR: begin
                acc.pair_op = 1'b1;
                acc.ok      = pair_capable(s);
            end
            default: acc.ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/bankreg_bank.sv
`timescale 1ns/1ps
module bankreg_bank
    import bankreg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  access_t                       acc,
    input  logic [2*DW-1:0]               wdata,
    output logic [NUM_SLOTS-1:0][DW-1:0]  q
);
    localparam int HW = DW / 2;

    logic commit;
    assign commit = we && acc.ok && !acc.stack;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (commit) begin
            if (acc.byte_op) begin
                if (acc.upper)
                    q[acc.lo][DW-1:HW] <= wdata[HW-1:0];
                else
                    q[acc.lo][HW-1:0]  <= wdata[HW-1:0];
            end else if (acc.pair_op) begin
                q[acc.lo] <= wdata[DW-1:0];
                q[acc.hi] <= wdata[2*DW-1:DW];
            end else begin
                q[acc.lo] <= wdata[DW-1:0];
            end
        end
    end
endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic              stack_sel,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [1:0]        wr_size,
    input  logic              wr_hi,
    input  logic [2*DW-1:0]   wr_data,
    output logic              wr_err,
    input  logic [2:0]        rd_sel,
    input  logic [1:0]        rd_size,
    input  logic              rd_hi,
    output logic [2*DW-1:0]   rd_data,
    output logic              rd_err
);
    localparam int HW     = DW / 2;
    localparam int NBANKS = 2;

    access_t wacc, racc;
    logic [NBANKS-1:0][NUM_SLOTS-1:0][DW-1:0] bank_q;
    logic [NUM_SLOTS-1:0][DW-1:0]             live;
    logic [DW-1:0]                            usp_q, isp_q, sp_view;

    bankreg_decode u_wdec (.sel(wr_sel), .size(wr_size), .half(wr_hi), .acc(wacc));
    bankreg_decode u_rdec (.sel(rd_sel), .size(rd_size), .half(rd_hi), .acc(racc));

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (int'(bank_sel) == b);
        bankreg_bank #(.DW(DW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we),
            .acc   (wacc),
            .wdata (wr_data),
            .q     (bank_q[b])
        );
    end

    // Stack pointers: one pair shared across banks
    always_ff @(posedge clk) begin
        if (rst) begin
            usp_q <= '0;
            isp_q <= '0;
        end else if (wr_en && wacc.ok && wacc.stack) begin
            if (stack_sel)
                isp_q <= wr_data[DW-1:0];
            else
                usp_q <= wr_data[DW-1:0];
        end
    end

    assign live    = bank_q[bank_sel];
    assign sp_view = stack_sel ? isp_q : usp_q;

    always_comb begin
        rd_data = '0;
        if (racc.ok) begin
            if (racc.stack) begin
                rd_data[DW-1:0] = sp_view;
            end else if (racc.byte_op) begin
                rd_data[HW-1:0] = racc.upper ? live[racc.lo][DW-1:HW]
                                             : live[racc.lo][HW-1:0];
            end else if (racc.pair_op) begin
                rd_data = {live[racc.hi], live[racc.lo]};
            end else begin
                rd_data[DW-1:0] = live[racc.lo];
            end
        end
    end

    assign wr_err = wr_en && !wacc.ok;
    assign rd_err = !racc.ok;
endmodule

// File: rtl/bankreg_file_chk.sv
`timescale 1ns/1ps
module bankreg_file_chk
    import bankreg_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                bank_sel,
    input logic                                stack_sel,
    input logic                                wr_en,
    input logic [2:0]                          wr_sel,
    input logic [1:0]                          wr_size,
    input logic                                wr_hi,
    input logic                                wr_err,
    input logic [1:0]                          rd_size,
    input logic [2*DW-1:0]                     rd_data,
    input logic                                rd_err,
    input logic [1:0][NUM_SLOTS-1:0][DW-1:0]   bank_q,
    input logic [DW-1:0]                       usp_q,
    input logic [DW-1:0]                       isp_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bank_q == '0 && usp_q == '0 && isp_q == '0));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_size != 2'b10) |-> (rd_data[2*DW-1:DW] == '0));

    a_r3_byte_keeps_other_half: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_size == 2'b00 && !wr_hi && wr_sel == 3'd0 && !bank_sel)
        |=> (bank_q[0][0][DW-1:DW/2] == $past(bank_q[0][0][DW-1:DW/2])));

    a_r5_reserved_size: assert property (@(posedge clk) disable iff (rst)
        (rd_size == 2'b11) |-> rd_err);

    a_r5_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));

    a_r5_bad_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_err) |=> ($stable(bank_q) && $stable(usp_q) && $stable(isp_q)));

    a_r6_bank1_idle: assert property (@(posedge clk) disable iff (rst)
        !bank_sel |=> $stable(bank_q[1]));

    a_r6_bank0_idle: assert property (@(posedge clk) disable iff (rst)
        bank_sel |=> $stable(bank_q[0]));

    a_r7_isp_idle: assert property (@(posedge clk) disable iff (rst)
        !stack_sel |=> $stable(isp_q));

    a_r7_usp_idle: assert property (@(posedge clk) disable iff (rst)
        stack_sel |=> $stable(usp_q));
endmodule

bind bankreg_file bankreg_file_chk #(.DW(DW)) chk (.*);

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;
    localparam int DW = 16;

    typedef struct packed {
        logic        we;
        logic        bank;
        logic        stk;
        logic [2:0]  wsel;
        logic [1:0]  wsz;
        logic        whi;
        logic [31:0] wd;
        logic [2:0]  rsel;
        logic [1:0]  rsz;
        logic        rhi;
        logic [31:0] exp;
        logic        rerr;
        logic        werr;
    } vec_t;

    localparam int NV = 23;
    // Each read observes state before the same vector's write.
    localparam vec_t VEC [NV] = '{
        // R8: read D0 while writing it -> old 0
        '{1'b1,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_1234, 3'd0,2'd1,1'b0,32'h0000_0000,1'b0,1'b0},
        // R2: word write D2, read D0
        '{1'b1,1'b0,1'b0,3'd2,2'd1,1'b0,32'h0000_ABCD, 3'd0,2'd1,1'b0,32'h0000_1234,1'b0,1'b0},
        // R4: pair read D2:D0; R3 byte write upper D0
        '{1'b1,1'b0,1'b0,3'd0,2'd0,1'b1,32'h0000_0055, 3'd0,2'd2,1'b0,32'hABCD_1234,1'b0,1'b0},
        // R3: upper half took 55, low kept 34; byte write lower
        '{1'b1,1'b0,1'b0,3'd0,2'd0,1'b0,32'h0000_0066, 3'd0,2'd1,1'b0,32'h0000_5534,1'b0,1'b0},
        // R4: pair write D3:D1; R3 byte read upper D0
        '{1'b1,1'b0,1'b0,3'd1,2'd2,1'b0,32'hCAFE_BEEF, 3'd0,2'd0,1'b1,32'h0000_0055,1'b0,1'b0},
        // R4: D3 got high word
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd3,2'd1,1'b0,32'h0000_CAFE,1'b0,1'b0},
        // R3: byte read lower D1
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd1,2'd0,1'b0,32'h0000_00EF,1'b0,1'b0},
        // R4: pair write AD1:AD0; read D1 word
        '{1'b1,1'b0,1'b0,3'd4,2'd2,1'b0,32'h1111_2222, 3'd1,2'd1,1'b0,32'h0000_BEEF,1'b0,1'b0},
        // R5: byte write on D2 illegal; R4 AD1 read
        '{1'b1,1'b0,1'b0,3'd2,2'd0,1'b0,32'h0000_0077, 3'd5,2'd1,1'b0,32'h0000_1111,1'b0,1'b1},
        // R5: D2 unchanged
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd2,2'd1,1'b0,32'h0000_ABCD,1'b0,1'b0},
        // R5: pair read on D2 illegal; R2 frame write
        '{1'b1,1'b0,1'b0,3'd6,2'd1,1'b0,32'h0000_0F0F, 3'd2,2'd2,1'b0,32'h0000_0000,1'b1,1'b0},
        // R7: user stack write; R2 frame read
        '{1'b1,1'b0,1'b0,3'd7,2'd1,1'b0,32'h0000_0100, 3'd6,2'd1,1'b0,32'h0000_0F0F,1'b0,1'b0},
        // R7 R8: interrupt stack write, read returns old 0
        '{1'b1,1'b0,1'b1,3'd7,2'd1,1'b0,32'h0000_0200, 3'd7,2'd1,1'b0,32'h0000_0000,1'b0,1'b0},
        // R7: user view
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd7,2'd1,1'b0,32'h0000_0100,1'b0,1'b0},
        // R7: interrupt view
        '{1'b0,1'b0,1'b1,3'd0,2'd1,1'b0,32'h0000_0000, 3'd7,2'd1,1'b0,32'h0000_0200,1'b0,1'b0},
        // R6: bank 1 D0 starts at 0
        '{1'b1,1'b1,1'b0,3'd0,2'd1,1'b0,32'h0000_9999, 3'd0,2'd1,1'b0,32'h0000_0000,1'b0,1'b0},
        // R5: reserved size write in bank 1; R6 read bank1 D0
        '{1'b1,1'b1,1'b0,3'd0,2'd3,1'b0,32'h0000_FFFF, 3'd0,2'd1,1'b0,32'h0000_9999,1'b0,1'b1},
        // R6: bank 0 D0 untouched
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd0,2'd1,1'b0,32'h0000_5566,1'b0,1'b0},
        // R7: stack pointer shared by bank 1
        '{1'b0,1'b1,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd7,2'd1,1'b0,32'h0000_0100,1'b0,1'b0},
        // R5: reserved-size write left bank1 D0
        '{1'b0,1'b1,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd0,2'd1,1'b0,32'h0000_9999,1'b0,1'b0},
        // R5: illegal write encoding without wr_en gives no error; R4 AD pair
        '{1'b0,1'b0,1'b0,3'd6,2'd2,1'b0,32'h0000_0000, 3'd4,2'd2,1'b0,32'h1111_2222,1'b0,1'b0},
        // R5: byte read on D2 illegal
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd2,2'd0,1'b0,32'h0000_0000,1'b1,1'b0},
        // R4: pair read D3:D1
        '{1'b0,1'b0,1'b0,3'd0,2'd1,1'b0,32'h0000_0000, 3'd1,2'd2,1'b0,32'hCAFE_BEEF,1'b0,1'b0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              bank_sel, stack_sel, wr_en, wr_hi, rd_hi;
    logic [2:0]        wr_sel, rd_sel;
    logic [1:0]        wr_size, rd_size;
    logic [2*DW-1:0]   wr_data, rd_data;
    logic              wr_err, rd_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bankreg_file #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .stack_sel(stack_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_err(wr_err), .rd_sel(rd_sel), .rd_size(rd_size),
        .rd_hi(rd_hi), .rd_data(rd_data), .rd_err(rd_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic b, input logic s, input logic [2:0] sel,
                           input logic [1:0] sz, input logic h);
        @(negedge clk);
        wr_en = 1'b0; bank_sel = b; stack_sel = s;
        rd_sel = sel; rd_size = sz; rd_hi = h;
        #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bank_sel = 1'b0; stack_sel = 1'b0; wr_en = 1'b0;
        wr_sel = '0; wr_size = 2'b01; wr_hi = 1'b0; wr_data = '0;
        rd_sel = '0; rd_size = 2'b01; rd_hi = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: state after reset
        read_at(1'b0, 1'b0, 3'd1, 2'd2, 1'b0);
        check("R1 pair D3:D1 after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].we; bank_sel = VEC[i].bank; stack_sel = VEC[i].stk;
            wr_sel = VEC[i].wsel; wr_size = VEC[i].wsz; wr_hi = VEC[i].whi;
            wr_data = VEC[i].wd;
            rd_sel = VEC[i].rsel; rd_size = VEC[i].rsz; rd_hi = VEC[i].rhi;
            #2;
            check($sformatf("vector %0d rd_data", i), rd_data, VEC[i].exp);
            check($sformatf("vector %0d rd_err", i), {31'b0, rd_err}, {31'b0, VEC[i].rerr});
            check($sformatf("vector %0d wr_err", i), {31'b0, wr_err}, {31'b0, VEC[i].werr});
        end

        // R5: reserved read size flags error
        read_at(1'b0, 1'b0, 3'd0, 2'd3, 1'b0);
        check("R5 reserved read size error", {31'b0, rd_err}, 32'h1);
        check("R5 reserved read size data", rd_data, 32'h0);

        // R1: reset again clears everything in both banks and both stack pointers
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_at(1'b0, 1'b0, 3'd0, 2'd2, 1'b0);
        check("R1 bank0 D2:D0 cleared", rd_data, 32'h0);
        read_at(1'b0, 1'b0, 3'd4, 2'd2, 1'b0);
        check("R1 bank0 AD pair cleared", rd_data, 32'h0);
        read_at(1'b1, 1'b0, 3'd0, 2'd1, 1'b0);
        check("R1 bank1 D0 cleared", rd_data, 32'h0);
        read_at(1'b0, 1'b0, 3'd7, 2'd1, 1'b0);
        check("R1 user stack cleared", rd_data, 32'h0);
        read_at(1'b0, 1'b1, 3'd7, 2'd1, 1'b0);
        check("R1 interrupt stack cleared", rd_data, 32'h0);

        finish_run();
    end
endmodule